// File: doc/BRIEF.md
# Packet Latency Stamper

This block sits in the data path between a traffic generator and a device under test (DUT). It measures round-trip latency by writing two hardware timestamps into the UDP payload of each frame. On the outbound pass, from the generator toward the DUT, the block writes a departure stamp. On the inbound pass, from the DUT back toward the generator, it writes an arrival stamp. Software subtracts the first stamp from the second to obtain the latency.

All streams are byte-wide, with valid, ready and last signals. Both paths are zero-latency pass-throughs. Each input ready is the matching output ready, so backpressure reaches the source in the same cycle, and no byte is held, lost or reordered. Frames that are not untagged IPv4 with a 20-byte header carrying UDP pass unchanged. UDP frames whose payload cannot hold both stamps also pass unchanged. IPv6 frames therefore pass unchanged.

Returning frames can also be mirrored to a monitor stream at a programmable 1-in-n rate. Four packet counters make loss visible: frames sent toward the DUT, frames received back, completed monitor copies, and copies dropped because the monitor was not ready. Comparing the first two counts shows packet loss.

Top module: `lat_stamper`

## Requirements
- R1: Every byte accepted on the generator input leaves on the DUT output in the same order, with the same last flag. The only changed bytes are the stamp bytes of R2. `gen_in_ready` equals `dut_out_ready` in every cycle.
- R2: A frame qualifies when all of the following hold, with byte 0 being the first byte of the frame:
  - bytes 12..13 are 0x08,0x00;
  - byte 14 is 0x45;
  - byte 23 is 17;
  - the UDP length in bytes 38..39 (big-endian) is at least 20.
  On the outbound path, a qualifying frame gets its departure stamp written over bytes 42..47, most significant byte first.
- R3: On the return path, a qualifying frame gets its arrival stamp written over bytes 48..53, most significant byte first. It is forwarded to the generator output with every other byte unchanged. `dut_in_ready` equals `gen_out_ready`.
- R4: A frame that does not qualify passes unchanged on both paths. This covers ethertype 0x86DD, header byte 0x46, protocol 6, and UDP length 19.
- R5: The timestamp is a 48-bit counter. It is zero during reset and advances by `NS_STEP` (default 10) on every clock edge after reset. A frame's stamp is the counter value in the cycle its first byte is accepted.
- R6: With `downscale` = n > 0, returning frames number n, 2n, 3n and so on (counted since reset or the last clear) are copied to the monitor output. A copy is byte-identical to the stamped generator output, and a monitor byte is valid only when the generator output transfers a byte.
- R7: With `downscale` = 0, no returning frame is copied to the monitor.
- R8: If the monitor is not ready in the cycle a selected frame's first byte transfers, that copy is skipped and `cnt_drop` increments. The return path is unaffected.
- R9: `cnt_to_dut` counts frames whose last byte transferred on the DUT output. `cnt_from_dut` counts last bytes accepted on the DUT input. `cnt_mon` counts last bytes of monitor copies. All four counters are `CNT_W` bits and wrap on overflow.
- R10: A cycle with `clear` high zeroes all four counters at the next edge and restarts the 1-in-n phase. A clear takes priority over any increment in the same cycle.
- R11: After reset, all counters read zero and no output valid is high while the inputs are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous counter and phase clear |
| downscale | input | DS_W | Monitor sampling factor n, 0 disables |
| gen_in_data | input | 8 | Byte from generator |
| gen_in_valid | input | 1 | Generator byte valid |
| gen_in_last | input | 1 | Last byte of generator frame |
| gen_in_ready | output | 1 | Generator byte accepted |
| dut_out_data | output | 8 | Byte toward DUT |
| dut_out_valid | output | 1 | DUT-bound byte valid |
| dut_out_last | output | 1 | Last byte toward DUT |
| dut_out_ready | input | 1 | DUT accepts byte |
| dut_in_data | input | 8 | Byte returning from DUT |
| dut_in_valid | input | 1 | Returning byte valid |
| dut_in_last | input | 1 | Last returning byte |
| dut_in_ready | output | 1 | Returning byte accepted |
| gen_out_data | output | 8 | Byte back to generator |
| gen_out_valid | output | 1 | Generator-bound byte valid |
| gen_out_last | output | 1 | Last generator-bound byte |
| gen_out_ready | input | 1 | Generator accepts byte |
| mon_data | output | 8 | Monitor copy byte |
| mon_valid | output | 1 | Monitor byte valid |
| mon_last | output | 1 | Last monitor byte |
| mon_ready | input | 1 | Monitor ready |
| cnt_to_dut | output | CNT_W | Frames sent toward DUT |
| cnt_from_dut | output | CNT_W | Frames received from DUT |
| cnt_mon | output | CNT_W | Completed monitor copies |
| cnt_drop | output | CNT_W | Monitor copies skipped |

## Verification
The assertions assume that upstream holds a byte steady while its valid is high and ready is low. They also assume that the monitor sink keeps its ready high for the whole of a copy once the copy has started, because a copy cannot be paused. The bench drives each byte at the falling edge and holds it until a rising edge that sees ready. It changes the monitor ready only between frames. It also changes `downscale` only while the return path is idle, so the phase counter never meets a factor that changes under a frame in flight.

// File: rtl/lat_stamp_pkg.sv
package lat_stamp_pkg;
  localparam int TS_W      = 48;
  localparam int TS_BYTES  = 6;
  localparam int IDX_ETYPE = 12;
  localparam int IDX_VIHL  = 14;
  localparam int IDX_PROTO = 23;
  localparam int IDX_ULEN  = 38;
  localparam int IDX_PAY   = 42;
  localparam logic [15:0] MIN_ULEN = 16'd20;

  typedef logic [TS_W-1:0] ts_t;

  typedef enum logic [1:0] {
    CNT_TO_DUT   = 2'd0,
    CNT_FROM_DUT = 2'd1,
    CNT_MON      = 2'd2,
    CNT_DROP     = 2'd3
  } cnt_sel_e;

  // byte k of a stamp, most significant first
  function automatic logic [7:0] ts_byte(input ts_t ts, input logic [2:0] k);
    ts_t sh;
    sh = ts >> (6'd40 - {k, 3'b000});
    return sh[7:0];
  endfunction
endpackage

// File: rtl/lat_ts_timer.sv
module lat_ts_timer
  import lat_stamp_pkg::*;
#(
  parameter int NS_STEP = 10
) (
  input  logic clk,
  input  logic rst_n,
  output ts_t  ts
);
  ts_t ts_q, ts_d;

  always_comb begin
    ts_d = ts_q + ts_t'(NS_STEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ts_q <= '0;
    else        ts_q <= ts_d;
  end

  assign ts = ts_q;

  AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ts_q == $past(ts_q) + ts_t'(NS_STEP))); // R5
endmodule

// File: rtl/lat_stamp_lane.sv
module lat_stamp_lane
  import lat_stamp_pkg::*;
#(
  parameter int SLOT_OFS = 0,
  parameter int IDX_W    = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  ts_t        ts_now,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_last,
  output logic       in_ready,
  output logic [7:0] out_data,
  output logic       out_valid,
  output logic       out_last,
  input  logic       out_ready
);
  localparam int BASE = IDX_PAY + SLOT_OFS;
  localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

  logic [IDX_W-1:0] idx_q, idx_d;
  ts_t              ts_q, ts_d;
  logic             hdr_ok_q, hdr_ok_d;
  logic [15:0]      ulen_q, ulen_d;
  logic             fire, in_win, qualified;
  logic [2:0]       k;

  assign fire      = in_valid & out_ready;
  assign in_win    = (idx_q >= IDX_W'(BASE)) && (idx_q < IDX_W'(BASE + TS_BYTES));
  assign k         = 3'(idx_q - IDX_W'(BASE));
  assign qualified = hdr_ok_q && (ulen_q >= MIN_ULEN);

  always_comb begin
    idx_d    = idx_q;
    ts_d     = ts_q;
    hdr_ok_d = hdr_ok_q;
    ulen_d   = ulen_q;
    if (fire) begin
      if (in_last)              idx_d = '0;
      else if (idx_q != IDX_MAX) idx_d = idx_q + 1'b1;
      if (idx_q == '0) begin
        ts_d     = ts_now;
        hdr_ok_d = 1'b1;
      end
      if (idx_q == IDX_W'(IDX_ETYPE))     hdr_ok_d = hdr_ok_q & (in_data == 8'h08);
      if (idx_q == IDX_W'(IDX_ETYPE + 1)) hdr_ok_d = hdr_ok_q & (in_data == 8'h00);
      if (idx_q == IDX_W'(IDX_VIHL))      hdr_ok_d = hdr_ok_q & (in_data == 8'h45);
      if (idx_q == IDX_W'(IDX_PROTO))     hdr_ok_d = hdr_ok_q & (in_data == 8'd17);
      if (idx_q == IDX_W'(IDX_ULEN))      ulen_d   = {in_data, ulen_q[7:0]};
      if (idx_q == IDX_W'(IDX_ULEN + 1))  ulen_d   = {ulen_q[15:8], in_data};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= '0;
      ts_q     <= '0;
      hdr_ok_q <= 1'b0;
      ulen_q   <= '0;
    end else begin
      idx_q    <= idx_d;
      ts_q     <= ts_d;
      hdr_ok_q <= hdr_ok_d;
      ulen_q   <= ulen_d;
    end
  end

  assign in_ready  = out_ready;
  assign out_valid = in_valid;
  assign out_last  = in_last;
  assign out_data  = (in_win && qualified) ? ts_byte(ts_q, k) : in_data;

  AST_TS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q != '0) |=> $stable(ts_q)); // R5
  AST_EDIT_ONLY_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_data != in_data)) |-> (hdr_ok_q && in_win)); // R4
endmodule

// File: rtl/lat_mon_sampler.sv
module lat_mon_sampler #(
  parameter int DS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [DS_W-1:0] downscale,
  input  logic            fire,
  input  logic            last,
  input  logic            mon_ready,
  output logic            copy_now,
  output logic            drop_pulse
);
  logic            sof_q, sof_d;
  logic            copy_q, copy_d;
  logic [DS_W-1:0] ph_q, ph_d;
  logic            enabled, hit, start;

  assign enabled    = (downscale != '0);
  assign hit        = enabled && (ph_q >= downscale - DS_W'(1));
  assign start      = fire & sof_q;
  assign copy_now   = sof_q ? (hit & mon_ready) : copy_q;
  assign drop_pulse = start & hit & ~mon_ready;

  always_comb begin
    sof_d  = sof_q;
    copy_d = copy_q;
    ph_d   = ph_q;
    if (fire) begin
      sof_d  = last;
      copy_d = last ? 1'b0 : copy_now;
    end
    if (clr)                  ph_d = '0;
    else if (start && enabled) ph_d = hit ? '0 : ph_q + DS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sof_q  <= 1'b1;
      copy_q <= 1'b0;
      ph_q   <= '0;
    end else begin
      sof_q  <= sof_d;
      copy_q <= copy_d;
      ph_q   <= ph_d;
    end
  end

  AST_DS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!enabled && sof_q) |-> !copy_now); // R7
  AST_DROP_NOT_COPIED: assert property (@(posedge clk) disable iff (!rst_n)
    drop_pulse |=> !copy_q); // R8
endmodule

// File: rtl/lat_pkt_counter.sv
module lat_pkt_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0)); // R10
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && inc) |=> (cnt_q == $past(cnt_q) + W'(1))); // R9
endmodule

// File: rtl/lat_stamper.sv
module lat_stamper
  import lat_stamp_pkg::*;
#(
  parameter int NS_STEP = 10,
  parameter int CNT_W   = 32,
  parameter int DS_W    = 16,
  parameter int IDX_W   = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [DS_W-1:0]  downscale,
  input  logic [7:0]       gen_in_data,
  input  logic             gen_in_valid,
  input  logic             gen_in_last,
  output logic             gen_in_ready,
  output logic [7:0]       dut_out_data,
  output logic             dut_out_valid,
  output logic             dut_out_last,
  input  logic             dut_out_ready,
  input  logic [7:0]       dut_in_data,
  input  logic             dut_in_valid,
  input  logic             dut_in_last,
  output logic             dut_in_ready,
  output logic [7:0]       gen_out_data,
  output logic             gen_out_valid,
  output logic             gen_out_last,
  input  logic             gen_out_ready,
  output logic [7:0]       mon_data,
  output logic             mon_valid,
  output logic             mon_last,
  input  logic             mon_ready,
  output logic [CNT_W-1:0] cnt_to_dut,
  output logic [CNT_W-1:0] cnt_from_dut,
  output logic [CNT_W-1:0] cnt_mon,
  output logic [CNT_W-1:0] cnt_drop
);
  localparam int N_CNT = 4;

  ts_t              ts_now;
  logic             ret_fire, copy_now, drop_pulse;
  logic [N_CNT-1:0] inc;
  logic [CNT_W-1:0] cnt_arr [N_CNT];

  lat_ts_timer #(.NS_STEP(NS_STEP)) i_timer (
    .clk(clk), .rst_n(rst_n), .ts(ts_now)
  );

  lat_stamp_lane #(.SLOT_OFS(0), .IDX_W(IDX_W)) i_lane_out (
    .clk(clk), .rst_n(rst_n), .ts_now(ts_now),
    .in_data(gen_in_data), .in_valid(gen_in_valid), .in_last(gen_in_last),
    .in_ready(gen_in_ready),
    .out_data(dut_out_data), .out_valid(dut_out_valid), .out_last(dut_out_last),
    .out_ready(dut_out_ready)
  );

  lat_stamp_lane #(.SLOT_OFS(TS_BYTES), .IDX_W(IDX_W)) i_lane_ret (
    .clk(clk), .rst_n(rst_n), .ts_now(ts_now),
    .in_data(dut_in_data), .in_valid(dut_in_valid), .in_last(dut_in_last),
    .in_ready(dut_in_ready),
    .out_data(gen_out_data), .out_valid(gen_out_valid), .out_last(gen_out_last),
    .out_ready(gen_out_ready)
  );

  assign ret_fire = dut_in_valid & gen_out_ready;

  lat_mon_sampler #(.DS_W(DS_W)) i_sampler (
    .clk(clk), .rst_n(rst_n), .clr(clear), .downscale(downscale),
    .fire(ret_fire), .last(dut_in_last), .mon_ready(mon_ready),
    .copy_now(copy_now), .drop_pulse(drop_pulse)
  );

  assign mon_valid = copy_now & ret_fire;
  assign mon_data  = gen_out_data;
  assign mon_last  = gen_out_last;

  assign inc[CNT_TO_DUT]   = dut_out_valid & dut_out_ready & dut_out_last;
  assign inc[CNT_FROM_DUT] = ret_fire & dut_in_last;
  assign inc[CNT_MON]      = mon_valid & mon_ready & mon_last;
  assign inc[CNT_DROP]     = drop_pulse;

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    lat_pkt_counter #(.W(CNT_W)) i_cnt (
      .clk(clk), .rst_n(rst_n), .clr(clear), .inc(inc[g]), .cnt(cnt_arr[g])
    );
  end

  assign cnt_to_dut   = cnt_arr[CNT_TO_DUT];
  assign cnt_from_dut = cnt_arr[CNT_FROM_DUT];
  assign cnt_mon      = cnt_arr[CNT_MON];
  assign cnt_drop     = cnt_arr[CNT_DROP];

  AST_MON_RIDES_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
    mon_valid |-> (gen_out_valid && gen_out_ready)); // R6
endmodule

// File: tb/test_lat_stamper.sv
module test_lat_stamper;
  localparam int STEP = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic clear;
  logic [15:0] downscale;
  logic [7:0] gi_d, do_d, di_d, go_d, mo_d;
  logic gi_v, gi_l, gi_r, do_v, do_l, do_r;
  logic di_v, di_l, di_r, go_v, go_l, go_r;
  logic mo_v, mo_l, mo_r;
  logic [31:0] c_to, c_from, c_mon, c_drop;

  always #5 clk = ~clk;

  lat_stamper i_lat_stamper (
    .clk(clk), .rst_n(rst_n), .clear(clear), .downscale(downscale),
    .gen_in_data(gi_d), .gen_in_valid(gi_v), .gen_in_last(gi_l), .gen_in_ready(gi_r),
    .dut_out_data(do_d), .dut_out_valid(do_v), .dut_out_last(do_l), .dut_out_ready(do_r),
    .dut_in_data(di_d), .dut_in_valid(di_v), .dut_in_last(di_l), .dut_in_ready(di_r),
    .gen_out_data(go_d), .gen_out_valid(go_v), .gen_out_last(go_l), .gen_out_ready(go_r),
    .mon_data(mo_d), .mon_valid(mo_v), .mon_last(mo_l), .mon_ready(mo_r),
    .cnt_to_dut(c_to), .cnt_from_dut(c_from), .cnt_mon(c_mon), .cnt_drop(c_drop)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  longint cyc;
  bit stall = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [7:0] pkt_b [0:127];
  logic [7:0] exp_b [0:127];
  logic [7:0] q_dut[$];
  logic [7:0] q_gen[$];
  logic [7:0] q_mon[$];
  int exp_to = 0, exp_from = 0, exp_mon = 0, exp_drop = 0;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
    if (do_v && do_r) q_dut.push_back(do_d);
    if (go_v && go_r) q_gen.push_back(go_d);
    if (mo_v && mo_r) q_mon.push_back(mo_d);
  end

  always @(negedge clk) begin
    if (stall) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      do_r = lfsr[0] | lfsr[3];
      go_r = lfsr[1] | lfsr[5];
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // kind: 0 IPv4/UDP, 1 IPv6, 2 IPv4 with IHL 6, 3 IPv4/TCP
  task automatic build(input int kind, input int len, input logic [15:0] ulen, input int tag);
    for (int i = 0; i < len; i++) pkt_b[i] = 8'(i * 3 + tag);
    pkt_b[0]  = 8'(tag);
    pkt_b[12] = (kind == 1) ? 8'h86 : 8'h08;
    pkt_b[13] = (kind == 1) ? 8'hDD : 8'h00;
    pkt_b[14] = (kind == 2) ? 8'h46 : ((kind == 1) ? 8'h60 : 8'h45);
    pkt_b[23] = (kind == 3) ? 8'd6 : 8'd17;
    pkt_b[38] = ulen[15:8];
    pkt_b[39] = ulen[7:0];
    for (int i = 0; i < len; i++) exp_b[i] = pkt_b[i];
  endtask

  task automatic put_stamp(input int base, input logic [47:0] ts);
    for (int k = 0; k < 6; k++) exp_b[base + k] = ts[47 - 8*k -: 8];
  endtask

  task automatic send(input int dir, input int len, output logic [47:0] ts);
    ts = '0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (dir == 0) begin gi_d = pkt_b[i]; gi_v = 1'b1; gi_l = (i == len - 1); end
      else          begin di_d = pkt_b[i]; di_v = 1'b1; di_l = (i == len - 1); end
      do @(posedge clk); while (!((dir == 0) ? gi_r : di_r));
      if (i == 0) ts = 48'(cyc * STEP);
    end
    @(negedge clk);
    gi_v = 1'b0; gi_l = 1'b0; di_v = 1'b0; di_l = 1'b0;
    if (dir == 0) exp_to++; else exp_from++;
  endtask

  task automatic cmp_q(input logic [7:0] q[$], input int len, input string req);
    int bad;
    int first;
    bad = 0; first = -1;
    chk(q.size() == len, req, "stream length", q.size(), len);
    for (int i = 0; i < len && i < q.size(); i++)
      if (q[i] !== exp_b[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    if (first >= 0) chk(1'b0, req, $sformatf("byte %0d", first), q[first], exp_b[first]);
    else checks++;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic flush();
    q_dut.delete(); q_gen.delete(); q_mon.delete();
  endtask

  task automatic chk_counters(input string req);
    chk(c_to == 32'(exp_to), req, "cnt_to_dut", c_to, exp_to);
    chk(c_from == 32'(exp_from), req, "cnt_from_dut", c_from, exp_from);
    chk(c_mon == 32'(exp_mon), req, "cnt_mon", c_mon, exp_mon);
    chk(c_drop == 32'(exp_drop), req, "cnt_drop", c_drop, exp_drop);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!do_v && !go_v && !mo_v, "R11", "valids idle", {do_v, go_v, mo_v}, 0);
    chk_counters("R11");
  endtask

  task automatic t_forward();
    logic [47:0] ts, ts2;
    build(0, 64, 16'd30, 1);
    send(0, 64, ts);
    settle();
    put_stamp(42, ts);
    cmp_q(q_dut, 64, "R2");
    chk(ts != 0, "R5", "stamp advanced", ts, 1);
    flush();
    build(0, 60, 16'd20, 9);
    send(0, 60, ts2);
    settle();
    put_stamp(42, ts2);
    cmp_q(q_dut, 60, "R5");
    chk((ts2 - ts) % STEP == 0 && ts2 > ts, "R5", "stamp step", ts2 - ts, STEP);
    flush();
  endtask

  task automatic t_forward_stall();
    logic [47:0] ts;
    stall = 1'b1;
    build(0, 70, 16'd36, 2);
    send(0, 70, ts);
    stall = 1'b0;
    @(negedge clk); do_r = 1'b1; go_r = 1'b1;
    settle();
    put_stamp(42, ts);
    cmp_q(q_dut, 70, "R1");
    flush();
  endtask

  task automatic t_return();
    logic [47:0] ts;
    stall = 1'b1;
    build(0, 64, 16'd30, 3);
    for (int k = 0; k < 6; k++) begin pkt_b[42 + k] = 8'hA0 + 8'(k); exp_b[42 + k] = pkt_b[42 + k]; end
    send(1, 64, ts);
    stall = 1'b0;
    @(negedge clk); do_r = 1'b1; go_r = 1'b1;
    settle();
    put_stamp(48, ts);
    cmp_q(q_gen, 64, "R3");
    chk(q_mon.size() == 0, "R7", "no copy at n=0", q_mon.size(), 0);
    flush();
  endtask

  task automatic t_pass();
    logic [47:0] ts;
    for (int kind = 1; kind < 4; kind++) begin
      build(kind, 64, 16'd30, 10 + kind);
      send(0, 64, ts);
      settle();
      cmp_q(q_dut, 64, "R4");
      flush();
    end
    build(0, 64, 16'd19, 20);
    send(1, 64, ts);
    settle();
    cmp_q(q_gen, 64, "R4");
    flush();
    chk_counters("R9");
  endtask

  task automatic t_clear();
    logic [47:0] ts;
    downscale = 16'd2;
    build(1, 20, 16'd0, 30);
    send(1, 20, ts);
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    exp_to = 0; exp_from = 0; exp_mon = 0; exp_drop = 0;
    chk_counters("R10");
    send(1, 20, ts);
    settle();
    chk(q_mon.size() == 0, "R10", "phase restarted", q_mon.size(), 0);
    send(1, 20, ts);
    settle();
    exp_mon++;
    chk(q_mon.size() == 20, "R10", "second after clear copied", q_mon.size(), 20);
    chk_counters("R10");
    flush();
    downscale = 16'd0;
  endtask

  task automatic t_monitor();
    logic [47:0] ts;
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    exp_to = 0; exp_from = 0; exp_mon = 0; exp_drop = 0;
    downscale = 16'd3;
    for (int p = 1; p <= 6; p++) begin
      build(1, 20, 16'd0, p);
      send(1, 20, ts);
    end
    settle();
    exp_mon += 2;
    chk(q_mon.size() == 40, "R6", "copy bytes n=3", q_mon.size(), 40);
    if (q_mon.size() == 40) begin
      chk(q_mon[0] == 8'd3, "R6", "first copy tag", q_mon[0], 3);
      chk(q_mon[20] == 8'd6, "R6", "second copy tag", q_mon[20], 6);
    end
    chk_counters("R6");
    flush();
    downscale = 16'd1;
    build(0, 64, 16'd30, 40);
    send(1, 64, ts);
    settle();
    exp_mon++;
    put_stamp(48, ts);
    cmp_q(q_mon, 64, "R6");
    cmp_q(q_gen, 64, "R6");
    flush();
  endtask

  task automatic t_ds0();
    logic [47:0] ts;
    downscale = 16'd0;
    for (int p = 0; p < 3; p++) begin
      build(1, 20, 16'd0, 50 + p);
      send(1, 20, ts);
    end
    settle();
    chk(q_mon.size() == 0, "R7", "no copies", q_mon.size(), 0);
    chk(c_mon == 32'(exp_mon), "R7", "cnt_mon unchanged", c_mon, exp_mon);
    flush();
  endtask

  task automatic t_drop();
    logic [47:0] ts;
    downscale = 16'd1;
    mo_r = 1'b0;
    build(0, 64, 16'd30, 60);
    send(1, 64, ts);
    settle();
    exp_drop++;
    put_stamp(48, ts);
    cmp_q(q_gen, 64, "R8");
    chk(q_mon.size() == 0, "R8", "copy skipped", q_mon.size(), 0);
    chk(c_drop == 32'(exp_drop), "R8", "cnt_drop", c_drop, exp_drop);
    chk_counters("R9");
    mo_r = 1'b1;
    downscale = 16'd0;
    flush();
  endtask

  initial begin
    rst_n = 1'b0; clear = 1'b0; downscale = 16'd0;
    gi_d = '0; gi_v = 1'b0; gi_l = 1'b0; di_d = '0; di_v = 1'b0; di_l = 1'b0;
    do_r = 1'b1; go_r = 1'b1; mo_r = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_forward();
    t_forward_stall();
    t_return();
    t_pass();
    t_clear();
    t_monitor();
    t_ds0();
    t_drop();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule